// File: doc/BRIEF.md
# Edge Counter, Edge Timestamper and PWM Timer Half

This block is one 16-bit counter half that can serve as one of three things. It can count edges on an input pin until a chosen count is reached. It can stamp the time of each edge by copying a free-running down-counter into a capture register. It can generate a PWM waveform whose duty cycle comes from a match value. A parameter can add an 8-bit prescale byte above the 16-bit counter. The byte then widens the load value, the match value, the counter and the captured value to 24 bits. The pin passes through a two-flop synchroniser, and the edge that counts can be rising, falling or both. The PWM output can be inverted. Two interrupt sources, capture event and capture match, each have a raw flag, a mask, a masked flag and a write-1-to-clear strobe.

A state machine with five states controls the counter. IDLE holds the count. IDLE moves to COUNT, STAMP or WAVE when enable is high, according to the mode, and loads the load value on that move. In mode 3 it stays in IDLE. COUNT moves to HELD when the match is reached. Every running state goes back to IDLE when enable falls. The mode is sampled only in IDLE.

Top module: `edge_pwm_timer`

## Requirements
- R1: After reset the counter, the capture register and both raw flags are zero, irq is low, and pwm_out equals the invert input.
- R2: The pin is synchronised by two flops. A pin change made between two clock edges acts on the third rising clock edge after that change. It has no effect on the first two.
- R3: edge_sel 2'b00 selects rising edges, 2'b01 selects falling edges, and 2'b10 or 2'b11 selects both. Edges that are not selected have no effect.
- R4: In mode 2'b00 (edge count) the counter is loaded on the move from IDLE. Each selected edge steps it by one toward the match value: down if it is above the match, up if it is below. An edge that finds the counter already equal to the match also reaches it. Reaching the match sets raw flag bit 1 (match) and enters HELD. In HELD the count ignores edges.
- R5: In mode 2'b01 (edge time) each selected edge copies the counter value from before that clock edge into capture_val and sets raw flag bit 0 (event).
- R6: In mode 2'b01 the counter counts down by one each clock cycle and reloads the load value in the cycle after it reads zero.
- R7: In mode 2'b10 (PWM) the counter counts down from the load value and reloads after zero. The uninverted output is high while the count is above the match value and low otherwise. Load L and match M give L-M high cycles in every L+1 cycles.
- R8: invert=1 flips pwm_out. Outside PWM mode pwm_out sits at the invert level.
- R9: With the prescaler enabled, the load, match, counter and capture values are {prescale byte, 16-bit value}, and all comparisons use the full 24 bits.
- R10: A 1 on an irq_clear bit clears that raw flag at the next clock edge. When a flag is set and cleared in the same cycle, the set wins.
- R11: irq_masked is irq_raw AND irq_mask, and irq is high when any masked bit is high.
- R12: The mode is sampled only when leaving IDLE, so changing it while running has no effect. Dropping enable returns to IDLE and holds the count. Mode 2'b11 keeps the block in IDLE. Enabling again reloads the load value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the selected mode |
| mode | input | 2 | 00 edge count, 01 edge time, 10 PWM, 11 none |
| edge_sel | input | 2 | 00 rising, 01 falling, 1x both |
| invert | input | 1 | Make the PWM output active low |
| load_val | input | CNT_W (16) | Start / reload value, low part |
| match_val | input | CNT_W (16) | Match value, low part |
| psc_load | input | PSC_W (8) | Prescale byte of the load value |
| psc_match | input | PSC_W (8) | Prescale byte of the match value |
| pin_in | input | 1 | Asynchronous event pin |
| irq_mask | input | 2 | Interrupt enables (bit 0 event, bit 1 match) |
| irq_clear | input | 2 | Write-1-to-clear strobes for the raw flags |
| count_val | output | FULL_W (24) | Current counter value |
| capture_val | output | FULL_W (24) | Last captured time stamp |
| pwm_out | output | 1 | PWM waveform after polarity |
| irq_raw | output | 2 | Raw flags (bit 0 event, bit 1 match) |
| irq_masked | output | 2 | Raw flags AND mask |
| irq | output | 1 | OR of the masked flags |

## Verification
Two functions can fall in the same cycle: a capture edge that sets the event flag, and a software clear strobe on that same flag. The bench places the pin change so that the third clock edge after it coincides with a one-cycle clear pulse. It then expects the flag to stay set and the capture register to hold the new time stamp. A clear pulse on its own, with no edge pending, must drop the flag. This control case separates "set wins" from "clear is ignored".

// File: rtl/ept_pkg.sv
package ept_pkg;

    typedef enum logic [1:0] {
        MODE_COUNT = 2'b00,
        MODE_TIME  = 2'b01,
        MODE_PWM   = 2'b10,
        MODE_NONE  = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_COUNT = 3'd1,
        ST_HELD  = 3'd2,
        ST_STAMP = 3'd3,
        ST_WAVE  = 3'd4
    } state_e;

    localparam int FLAG_EVT   = 0;
    localparam int FLAG_MATCH = 1;
    localparam int NUM_FLAGS  = 2;

endpackage

// File: rtl/ept_edge_detect.sv
module ept_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;
    logic            rise;
    logic            fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SH_W-2:0], pin_in};
    end

    assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    assign fall = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];

    always_comb begin
        unique case (edge_sel)
            2'b00:   hit = rise;
            2'b01:   hit = fall;
            default: hit = rise | fall;
        endcase
    end

    // cycles since reset, so that $past never reaches before it
    logic [3:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 4'hF) age <= age + 4'd1;
    end

    p_rise_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && (age > 4'(SYNC_STAGES))) |->
            ($past(pin_in, SYNC_STAGES) && !$past(pin_in, SYNC_STAGES + 1)));

    p_edge_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00 && fall) |-> !hit);

endmodule

// File: rtl/ept_flags.sv
module ept_flags
    import ept_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_in,
    input  logic [NUM_FLAGS-1:0] clr_in,
    input  logic [NUM_FLAGS-1:0] mask_in,
    output logic [NUM_FLAGS-1:0] raw,
    output logic [NUM_FLAGS-1:0] masked,
    output logic                 irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_in) | set_in;
    end

    assign masked = raw & mask_in;
    assign irq    = |masked;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_in[i] |=> raw[i]);
        p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_in[i] && !set_in[i]) |=> !raw[i]);
        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_in[i] && !set_in[i]) |=> $stable(raw[i]));
    end

endmodule

// File: rtl/ept_core.sv
module ept_core
    import ept_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  mode_e         mode,
    input  logic [CW-1:0] load_v,
    input  logic [CW-1:0] match_v,
    input  logic          hit,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cap,
    output logic          evt_pulse,
    output logic          match_pulse,
    output logic          wave_hi
);
    state_e        st, st_n;
    logic [CW-1:0] cnt_n, cap_n, stepped;
    logic          evt_c, mth_c;

    // next state and datapath
    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        cap_n   = cap;
        evt_c   = 1'b0;
        mth_c   = 1'b0;
        stepped = (cnt > match_v) ? cnt - 1'b1 : cnt + 1'b1;
        unique case (st)
            ST_IDLE: begin
                if (enable) begin
                    unique case (mode)
                        MODE_COUNT: begin st_n = ST_COUNT; cnt_n = load_v; end
                        MODE_TIME:  begin st_n = ST_STAMP; cnt_n = load_v; end
                        MODE_PWM:   begin st_n = ST_WAVE;  cnt_n = load_v; end
                        default:    st_n = ST_IDLE;
                    endcase
                end
            end
            ST_COUNT: begin
                if (!enable) begin
                    st_n = ST_IDLE;
                end else if (hit) begin
                    if (cnt == match_v) begin
                        mth_c = 1'b1;
                        st_n  = ST_HELD;
                    end else begin
                        cnt_n = stepped;
                        if (stepped == match_v) begin
                            mth_c = 1'b1;
                            st_n  = ST_HELD;
                        end
                    end
                end
            end
            ST_HELD: begin
                if (!enable) st_n = ST_IDLE;
            end
            ST_STAMP: begin
                if (!enable) begin
                    st_n = ST_IDLE;
                end else begin
                    cnt_n = (cnt == '0) ? load_v : cnt - 1'b1;
                    if (hit) begin
                        cap_n = cnt;
                        evt_c = 1'b1;
                    end
                end
            end
            ST_WAVE: begin
                if (!enable) st_n = ST_IDLE;
                else         cnt_n = (cnt == '0) ? load_v : cnt - 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            cap <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            cap <= cap_n;
        end
    end

    // outputs
    always_comb begin
        evt_pulse   = evt_c;
        match_pulse = mth_c;
        wave_hi     = (st == ST_WAVE) && (cnt > match_v);
    end

    p_held_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HELD) |=> $stable(cnt));

    p_stamp_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STAMP && enable && hit) |=> (cap == $past(cnt)));

    p_wave_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAVE && enable && cnt == '0) |=> (cnt == $past(load_v)));

    p_reserved_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && mode == MODE_NONE) |=> (st == ST_IDLE));

endmodule

// File: rtl/edge_pwm_timer.sv
module edge_pwm_timer
    import ept_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 8,
    parameter bit PSC_EN      = 1'b1,
    parameter int SYNC_STAGES = 2,
    localparam int FULL_W     = CNT_W + (PSC_EN ? PSC_W : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic [1:0]        edge_sel,
    input  logic              invert,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  match_val,
    input  logic [PSC_W-1:0]  psc_load,
    input  logic [PSC_W-1:0]  psc_match,
    input  logic              pin_in,
    input  logic [1:0]        irq_mask,
    input  logic [1:0]        irq_clear,
    output logic [FULL_W-1:0] count_val,
    output logic [FULL_W-1:0] capture_val,
    output logic              pwm_out,
    output logic [1:0]        irq_raw,
    output logic [1:0]        irq_masked,
    output logic              irq
);
    logic [FULL_W-1:0]    load_full, match_full;
    logic                 hit, evt_p, mth_p, wave_hi;
    logic [NUM_FLAGS-1:0] set_v;

    if (PSC_EN) begin : g_psc
        assign load_full  = {psc_load, load_val};
        assign match_full = {psc_match, match_val};
    end else begin : g_nopsc
        assign load_full  = load_val;
        assign match_full = match_val;
    end

    ept_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .edge_sel (edge_sel),
        .hit      (hit)
    );

    ept_core #(.CW(FULL_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .mode        (mode_e'(mode)),
        .load_v      (load_full),
        .match_v     (match_full),
        .hit         (hit),
        .cnt         (count_val),
        .cap         (capture_val),
        .evt_pulse   (evt_p),
        .match_pulse (mth_p),
        .wave_hi     (wave_hi)
    );

    always_comb begin
        set_v             = '0;
        set_v[FLAG_EVT]   = evt_p;
        set_v[FLAG_MATCH] = mth_p;
    end

    ept_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_in  (set_v),
        .clr_in  (irq_clear),
        .mask_in (irq_mask),
        .raw     (irq_raw),
        .masked  (irq_masked),
        .irq     (irq)
    );

    assign pwm_out = invert ^ wave_hi;

    p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> (pwm_out == invert));

endmodule

// File: tb/sim_edge_pwm_timer.sv
`timescale 1ns/1ps
module sim_edge_pwm_timer;

    localparam int FW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [1:0] edge_sel = 2'b00;
    logic invert = 1'b0;
    logic [15:0] load_val = '0;
    logic [15:0] match_val = '0;
    logic [7:0] psc_load = '0;
    logic [7:0] psc_match = '0;
    logic pin_in = 1'b0;
    logic [1:0] irq_mask = '0;
    logic [1:0] irq_clear = '0;
    logic [FW-1:0] count_val, capture_val;
    logic pwm_out, irq;
    logic [1:0] irq_raw, irq_masked;

    always #2 clk = ~clk;

    edge_pwm_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .edge_sel(edge_sel), .invert(invert), .load_val(load_val),
        .match_val(match_val), .psc_load(psc_load), .psc_match(psc_match),
        .pin_in(pin_in), .irq_mask(irq_mask), .irq_clear(irq_clear),
        .count_val(count_val), .capture_val(capture_val), .pwm_out(pwm_out),
        .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq)
    );

    localparam int S_CNT = 0, S_CAP = 1, S_RAW = 2, S_MSK = 3,
                   S_IRQ = 4, S_PWM = 5, S_FIX = 6;

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
        logic [31:0] fixed;
    } item_t;

    item_t sb_q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    function automatic logic [31:0] observe(item_t it);
        case (it.sel)
            S_CNT:   return 32'(count_val);
            S_CAP:   return 32'(capture_val);
            S_RAW:   return 32'(irq_raw);
            S_MSK:   return 32'(irq_masked);
            S_IRQ:   return 32'(irq);
            S_PWM:   return 32'(pwm_out);
            default: return it.fixed;
        endcase
    endfunction

    // monitor: drains expectations one time unit after each falling edge
    initial begin
        item_t it;
        logic [31:0] got;
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                got = observe(it);
                compared++;
                if (got !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s sel=%0d got=%0h expected=%0h", it.tag, it.sel, got, it.exp);
                end
            end
        end
    end

    task automatic expect_out(input string tag, input int sel, input logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp; it.fixed = '0;
        sb_q.push_back(it);
    endtask

    task automatic expect_fixed(input string tag, input logic [31:0] got, input logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = S_FIX; it.exp = exp; it.fixed = got;
        sb_q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        pin_in = 1'b1; tick(4);
        pin_in = 1'b0; tick(4);
    endtask

    task automatic wclear(input logic [1:0] b);
        irq_clear = b; tick(1); irq_clear = 2'b00;
    endtask

    initial begin
        #400000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog got=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int hi;
        logic [FW-1:0] c1;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        expect_out("R1 count", S_CNT, 0);
        expect_out("R1 capture", S_CAP, 0);
        expect_out("R1 raw", S_RAW, 0);
        expect_out("R1 irq", S_IRQ, 0);
        expect_out("R1 pwm", S_PWM, 0);
        tick(1);
        invert = 1'b1; tick(1);
        expect_out("R8 idle level inverted", S_PWM, 1);
        tick(1);
        invert = 1'b0;

        // edge count, rising, load 5 match 2
        irq_mask = 2'b11;
        mode = 2'b00; edge_sel = 2'b00; load_val = 5; match_val = 2;
        enable = 1'b1; tick(1);
        expect_out("R4 loaded", S_CNT, 5);
        pin_in = 1'b1; tick(2);
        expect_out("R2 not yet", S_CNT, 5);
        tick(1);
        expect_out("R2 third edge", S_CNT, 4);
        tick(1);
        pin_in = 1'b0; tick(4);
        expect_out("R3 fall ignored", S_CNT, 4);
        tick(1);
        pulse();
        expect_out("R4 step", S_CNT, 3);
        expect_out("R4 no match yet", S_RAW, 0);
        tick(1);
        pulse();
        expect_out("R4 reached", S_CNT, 2);
        expect_out("R4 match flag", S_RAW, 2'b10);
        expect_out("R11 irq", S_IRQ, 1);
        tick(1);
        pulse();
        expect_out("R4 held", S_CNT, 2);
        tick(1);
        irq_mask = 2'b01;
        expect_out("R11 masked off", S_MSK, 0);
        expect_out("R11 irq off", S_IRQ, 0);
        expect_out("R11 raw kept", S_RAW, 2'b10);
        tick(1);
        irq_mask = 2'b11;
        wclear(2'b10);
        expect_out("R10 cleared", S_RAW, 0);
        tick(1);
        enable = 1'b0; tick(1);

        // falling edges, counting up
        edge_sel = 2'b01; load_val = 0; match_val = 3;
        enable = 1'b1; tick(1);
        pin_in = 1'b1; tick(4);
        expect_out("R3 rise ignored", S_CNT, 0);
        tick(1);
        pin_in = 1'b0; tick(4);
        expect_out("R3 fall counted up", S_CNT, 1);
        tick(1);
        enable = 1'b0; tick(1);

        // both edges, load 10 match 8
        edge_sel = 2'b11; load_val = 10; match_val = 8;
        enable = 1'b1; tick(1);
        pulse();
        expect_out("R3 both edges", S_CNT, 8);
        expect_out("R3 both match", S_RAW, 2'b10);
        tick(1);
        wclear(2'b10);
        enable = 1'b0; tick(1);

        // edge time, load 100
        mode = 2'b01; edge_sel = 2'b00; load_val = 100;
        enable = 1'b1; tick(1);
        expect_out("R6 loaded", S_CNT, 100);
        pin_in = 1'b1; tick(3);
        expect_out("R5 stamp", S_CAP, 98);
        expect_out("R5 event", S_RAW, 2'b01);
        pin_in = 1'b0; tick(4);
        pin_in = 1'b1; tick(2);
        irq_clear = 2'b01; tick(1);
        irq_clear = 2'b00;
        expect_out("R10 set wins", S_RAW, 2'b01);
        expect_out("R5 second stamp", S_CAP, 91);
        tick(1);
        wclear(2'b01);
        expect_out("R10 plain clear", S_RAW, 0);
        tick(1);
        pin_in = 1'b0; tick(4);
        enable = 1'b0; tick(1);

        // edge time reload with load 2
        load_val = 2;
        enable = 1'b1; tick(1);
        expect_out("R6 start", S_CNT, 2);
        tick(1); expect_out("R6 down", S_CNT, 1);
        tick(1); expect_out("R6 zero", S_CNT, 0);
        tick(1); expect_out("R6 reload", S_CNT, 2);
        tick(1);
        enable = 1'b0; tick(1);

        // prescale byte
        psc_load = 8'h01; load_val = 16'h0005;
        enable = 1'b1; tick(1);
        expect_out("R9 wide load", S_CNT, 24'h010005);
        pin_in = 1'b1; tick(3);
        expect_out("R9 wide stamp", S_CAP, 24'h010003);
        pin_in = 1'b0; tick(4);
        enable = 1'b0; tick(1);
        wclear(2'b01);
        mode = 2'b00; load_val = 16'h0002; psc_match = 8'h00; match_val = 16'hFFFF;
        enable = 1'b1; tick(1);
        pulse(); pulse();
        expect_out("R9 no early match", S_RAW, 0);
        tick(1);
        pulse();
        expect_out("R9 wide count", S_CNT, 24'h00FFFF);
        expect_out("R9 wide match", S_RAW, 2'b10);
        tick(1);
        wclear(2'b10);
        enable = 1'b0; tick(1);
        psc_load = 8'h00;

        // PWM, load 9 match 6
        mode = 2'b10; load_val = 9; match_val = 6; invert = 1'b0;
        enable = 1'b1; tick(1);
        expect_out("R7 start", S_CNT, 9);
        expect_out("R7 high at reload", S_PWM, 1);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            hi += int'(pwm_out);
        end
        expect_fixed("R7 duty", 32'(hi), 6);
        tick(1);
        invert = 1'b1;
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            hi += int'(pwm_out);
        end
        expect_fixed("R8 inverted duty", 32'(hi), 14);
        tick(1);
        mode = 2'b00; tick(1);
        c1 = count_val;
        tick(1);
        expect_out("R12 mode ignored", S_CNT, (c1 == 0) ? 32'd9 : 32'(c1) - 1);
        tick(1);
        enable = 1'b0; tick(1);
        c1 = count_val;
        tick(3);
        expect_out("R12 held in idle", S_CNT, 32'(c1));
        expect_out("R8 idle level", S_PWM, 1);
        tick(1);
        mode = 2'b11; load_val = 7;
        enable = 1'b1; tick(2);
        expect_out("R12 reserved mode", S_CNT, 32'(c1));
        tick(1);
        enable = 1'b0; tick(1);
        mode = 2'b10; invert = 1'b0;
        enable = 1'b1; tick(1);
        expect_out("R12 reload on enable", S_CNT, 7);
        tick(1);
        enable = 1'b0;
        tick(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule